// File: doc/BRIEF.md
# Cascadable Pulse Accumulator Pair

The block holds two 8-bit counters. Each counts rising edges on its own pulse input. A cascade input joins the two counters into one 16-bit accumulator. In that mode the low counter counts edges on pulse input 0. Each time it rolls from 0xFF to 0x00, its carry advances the high counter. When the joined count rolls past 0xFFFF, an overflow flag is set. The flag is cleared by writing a one to it, and it drives an interrupt output through an enable input.

Software reaches the counters through a small synchronous register bus. A word access at the count address reads or loads both bytes in the same clock cycle. A byte access reaches one counter only, so two byte reads can see a count that moved between them. A bus write to a counter always wins over an increment in the same cycle.

The cascade choice is a two-state machine.
- States: `MODE_SPLIT` (independent counters, the reset state) and `MODE_CASC` (joined).
- Transition JOIN goes from `MODE_SPLIT` to `MODE_CASC` when `casc_en` is sampled high.
- Transition PART goes from `MODE_CASC` to `MODE_SPLIT` when `casc_en` is sampled low.
- Otherwise the state holds.

Top module: `pacc_pair`

## Requirements
- R1: Synchronous reset clears both counters and the overflow flag and drives `irq` low.
- R2: Each pulse input passes through two synchronizer flops and an edge detector. A rise first seen at clock edge n increments its counter at edge n+2. A level held high counts only once.
- R3: In split mode, `pulse_in[0]` counts the low counter and `pulse_in[1]` counts the high counter. A low-counter wrap from 0xFF to 0x00 leaves the high counter untouched.
- R4: In cascade mode, the low counter counts `pulse_in[0]`, and the high counter advances only in a cycle where the low counter wraps from 0xFF to 0x00. `pulse_in[1]` has no effect.
- R5: In cascade mode, a high-counter wrap from 0xFF to 0x00 sets the flag. In split mode, no wrap sets it.
- R6: Writing a value with bit 0 set to address 2 clears the flag, and a zero in bit 0 leaves it unchanged. If a set and a clear fall in the same cycle, the flag ends set.
- R7: `irq` equals the flag ANDed with `irq_en`.
- R8: A word access (`bus_word`=1) at address 0 reads {high,low} on `bus_rdata[15:0]` in the same cycle. A word write there loads the high counter from `bus_wdata[15:8]` and the low counter from `bus_wdata[7:0]` at one clock edge.
- R9: Byte accesses use data bits 7:0. Address 0 is the high counter and address 1 the low counter. A byte write loads only the addressed counter. `bus_word` is ignored at addresses 1 to 3.
- R10: A write to a counter in a cycle where it would increment loads the written value and drops the increment. In cascade mode, a carry raised by the low counter is then not generated (low written) or not applied (high written), and no overflow follows.
- R11: The mode follows `casc_en` as sampled at the previous clock edge.
- R12: `bus_rdata` is zero unless `bus_sel`=1 and `bus_wr`=0. Address 2 reads the flag in bit 0, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 2 | Pulse inputs, bit 0 low counter, bit 1 high counter |
| casc_en | input | 1 | Join the counters into one 16-bit accumulator |
| irq_en | input | 1 | Interrupt enable for the overflow flag |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_word | input | 1 | 16-bit access at address 0 |
| bus_addr | input | 2 | 0 high count, 1 low count, 2 flag, 3 unused |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume the bus and mode inputs are synchronous to `clk` and hold known values while reset is low. They make no assumption about the pulse inputs, which may toggle at any rate that gives each level at least one clock. To stay within this, the bench drives every input only at the falling edge, and it holds pulse levels for whole cycles. Random traffic mixes collisions, mode flips and flag writes under these same timing rules.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        REG_HI   = 2'd0,
        REG_LO   = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_CASC  = 1'b1
    } mode_e;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_LO  = 0;
    localparam int unsigned CH_HI  = 1;
endpackage

// File: rtl/pacc_edge_sync.sv
module pacc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for the edge
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], pin};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         carry
);
    localparam logic [W-1:0] TOP = '1;

    // a load suppresses both the increment and its carry
    assign carry = inc & ~ld & (q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/pacc_regbus.sv
module pacc_regbus
    import pacc_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned DW = 2 * W
) (
    input  logic          sel,
    input  logic          wr,
    input  logic          word,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [W-1:0]  q_hi,
    input  logic [W-1:0]  q_lo,
    input  logic          flag,
    output logic          ld_hi,
    output logic          ld_lo,
    output logic [W-1:0]  val_hi,
    output logic [W-1:0]  val_lo,
    output logic          flag_clr,
    output logic [DW-1:0] rdata
);
    reg_sel_e rsel;
    logic     wide;

    assign rsel = reg_sel_e'(addr);
    assign wide = word && (rsel == REG_HI);

    always_comb begin
        ld_hi    = 1'b0;
        ld_lo    = 1'b0;
        flag_clr = 1'b0;
        rdata    = '0;
        val_hi   = wide ? wdata[DW-1:W] : wdata[W-1:0];
        val_lo   = wdata[W-1:0];
        if (sel) begin
            unique case (rsel)
                REG_HI: begin
                    if (wr) begin
                        ld_hi = 1'b1;
                        ld_lo = wide;
                    end else begin
                        rdata = wide ? {q_hi, q_lo} : {{W{1'b0}}, q_hi};
                    end
                end
                REG_LO: begin
                    if (wr) ld_lo = 1'b1;
                    else    rdata = {{W{1'b0}}, q_lo};
                end
                REG_FLAG: begin
                    if (wr) flag_clr = wdata[0];
                    else    rdata = {{(DW-1){1'b0}}, flag};
                end
                REG_NONE: begin
                    rdata = '0;
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pacc_pair.sv
module pacc_pair
    import pacc_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned DW = 2 * CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    pulse_in,
    input  logic          casc_en,
    input  logic          irq_en,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_word,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    mode_e mode_q, mode_d;

    logic [NUM_CH-1:0]            rise;
    logic [NUM_CH-1:0]            inc;
    logic [NUM_CH-1:0]            ld;
    logic [NUM_CH-1:0]            carry;
    logic [NUM_CH-1:0][CNT_W-1:0] ld_val;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;

    logic             flag_q;
    logic             flag_clr;
    logic             ovf_set;
    logic [CNT_W-1:0] cnt_lo, cnt_hi, val_lo, val_hi;
    logic             ld_lo, ld_hi, inc_lo;

    // one synchronizer and one counter per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pacc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .pin  (pulse_in[ch]),
            .rise (rise[ch])
        );
        pacc_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld[ch]),
            .ld_val (ld_val[ch]),
            .inc    (inc[ch]),
            .q      (cnt_q[ch]),
            .carry  (carry[ch])
        );
    end

    pacc_regbus #(.W(CNT_W)) u_bus (
        .sel      (bus_sel),
        .wr       (bus_wr),
        .word     (bus_word),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .q_hi     (cnt_q[CH_HI]),
        .q_lo     (cnt_q[CH_LO]),
        .flag     (flag_q),
        .ld_hi    (ld[CH_HI]),
        .ld_lo    (ld[CH_LO]),
        .val_hi   (ld_val[CH_HI]),
        .val_lo   (ld_val[CH_LO]),
        .flag_clr (flag_clr),
        .rdata    (bus_rdata)
    );

    // mode state register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_SPLIT;
        else     mode_q <= mode_d;
    end

    // transitions JOIN and PART
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SPLIT: if (casc_en)  mode_d = MODE_CASC;
            MODE_CASC:  if (!casc_en) mode_d = MODE_SPLIT;
            default:    mode_d = MODE_SPLIT;
        endcase
    end

    // per-state routing of increments and overflow
    always_comb begin
        inc[CH_LO] = rise[CH_LO];
        inc[CH_HI] = 1'b0;
        ovf_set    = 1'b0;
        unique case (mode_q)
            MODE_SPLIT: inc[CH_HI] = rise[CH_HI];
            MODE_CASC: begin
                inc[CH_HI] = carry[CH_LO];
                ovf_set    = carry[CH_HI];
            end
            default: inc[CH_HI] = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (ovf_set)  flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & irq_en;

    // flat views for the bound checker
    assign cnt_lo = cnt_q[CH_LO];
    assign cnt_hi = cnt_q[CH_HI];
    assign val_lo = ld_val[CH_LO];
    assign val_hi = ld_val[CH_HI];
    assign ld_lo  = ld[CH_LO];
    assign ld_hi  = ld[CH_HI];
    assign inc_lo = inc[CH_LO];
endmodule

// File: rtl/pacc_pair_chk.sv
module pacc_pair_chk
    import pacc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input mode_e        mode_q,
    input logic         ld_lo,
    input logic         ld_hi,
    input logic         inc_lo,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi,
    input logic [W-1:0] val_lo,
    input logic [W-1:0] val_hi,
    input logic         flag_q,
    input logic         flag_clr,
    input logic         ovf_set
);
    localparam logic [W-1:0] TOP = '1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cnt_lo == '0 && cnt_hi == '0 && !flag_q));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ld_lo && !inc_lo) |=> $stable(cnt_lo));

    assert_carry_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_CASC && inc_lo && !ld_lo && !ld_hi && cnt_lo == TOP)
        |=> cnt_hi == W'($past(cnt_hi) + 1'b1));

    assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> flag_q);

    assert_split_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SPLIT && !flag_q) |=> !flag_q);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && flag_clr && !ovf_set) |=> !flag_q);

    assert_wr_lo_wins_R10: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> cnt_lo == $past(val_lo));

    assert_wr_hi_wins_R10: assert property (@(posedge clk) disable iff (rst)
        ld_hi |=> cnt_hi == $past(val_hi));
endmodule

bind pacc_pair pacc_pair_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .ld_lo    (ld_lo),
    .ld_hi    (ld_hi),
    .inc_lo   (inc_lo),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .val_lo   (val_lo),
    .val_hi   (val_hi),
    .flag_q   (flag_q),
    .flag_clr (flag_clr),
    .ovf_set  (ovf_set)
);

// File: tb/pacc_pair_tb.sv
module pacc_pair_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  pin = 2'b00;
    logic        casc_en = 1'b0;
    logic        irq_en = 1'b1;
    logic        sel = 1'b1, wr = 1'b0, word = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference state
    int m_lo, m_hi;
    bit m_flag, m_casc;
    int h0[$];
    int h1[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pacc_pair u_dut (
        .clk       (clk),
        .rst       (rst),
        .pulse_in  (pin),
        .casc_en   (casc_en),
        .irq_en    (irq_en),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_word  (word),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // reference model, updated at each rising edge
    always @(posedge clk) begin
        bit r0, r1, wl, wh, clr, cy, hinc, set;
        int vl, vh;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_flag = 0; m_casc = 0;
            h0 = '{0, 0, 0};
            h1 = '{0, 0, 0};
        end else begin
            // rise first seen two edges back counts now
            r0 = (h0[1] == 1) && (h0[2] == 0);
            r1 = (h1[1] == 1) && (h1[2] == 0);
            wl = 0; wh = 0; clr = 0;
            vl = wdata[7:0]; vh = wdata[7:0];
            if (sel && wr) begin
                if (addr == 0) begin
                    wh = 1;
                    if (word) begin wl = 1; vh = wdata[15:8]; end
                end else if (addr == 1) wl = 1;
                else if (addr == 2) clr = wdata[0];
            end
            cy = r0 && !wl && (m_lo == 255);
            hinc = m_casc ? cy : r1;
            set = m_casc && hinc && !wh && (m_hi == 255);
            if (wl) m_lo = vl; else if (r0) m_lo = (m_lo + 1) % 256;
            if (wh) m_hi = vh; else if (hinc) m_hi = (m_hi + 1) % 256;
            if (set) m_flag = 1; else if (clr) m_flag = 0;
            h0.push_front(int'(pin[0])); void'(h0.pop_back());
            h1.push_front(int'(pin[1])); void'(h1.pop_back());
            m_casc = casc_en;
        end
    end

    function automatic logic [15:0] exp_rd();
        if (!(sel && !wr)) return 16'h0;
        case (addr)
            2'd0: return word ? 16'((m_hi << 8) | m_lo) : 16'(m_hi);
            2'd1: return 16'(m_lo);
            2'd2: return {15'h0, m_flag};
            default: return 16'h0;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            check({cur_req, " rdata vs model"}, 32'(rdata), 32'(exp_rd()));
            check({"R7 irq vs model (", cur_req, ")"}, 32'(irq), 32'(m_flag & irq_en));
        end
    end

    task automatic idle();
        sel = 1; wr = 0; word = 1; addr = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic w, logic [15:0] d);
        @(negedge clk);
        sel = 1; wr = 1; word = w; addr = a; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic w, logic [15:0] e);
        @(negedge clk);
        sel = 1; wr = 0; word = w; addr = a;
        #1;
        check(req, 32'(rdata), 32'(e));
    endtask

    task automatic pulse(int ch);
        @(negedge clk); pin[ch] = 1'b1;
        @(negedge clk); pin[ch] = 1'b0;
    endtask

    // write lands on the edge where the pulse increments
    task automatic pulse_with_write(int ch, logic [1:0] a, logic w, logic [15:0] d);
        @(negedge clk); pin[ch] = 1'b1;
        @(negedge clk); pin[ch] = 1'b0;
        @(negedge clk);
        sel = 1; wr = 1; word = w; addr = a; wdata = d;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        idle();
        wait_cyc(3);
        rst = 1'b0;

        cur_req = "R1";
        rd_chk("R1 reset count", 2'd0, 1'b1, 16'h0000);
        rd_chk("R1 reset flag", 2'd2, 1'b0, 16'h0000);
        check("R1 reset irq", 32'(irq), 32'h0);

        cur_req = "R2";
        @(negedge clk); pin[0] = 1'b1;
        wait_cyc(10);
        pin[0] = 1'b0;
        wait_cyc(4);
        rd_chk("R2 held level counts once", 2'd0, 1'b1, 16'h0001);

        cur_req = "R3";
        bus_write(2'd1, 1'b0, 16'h00FE);
        for (int i = 0; i < 3; i++) pulse(0);
        pulse(1); pulse(1);
        wait_cyc(4);
        rd_chk("R3 split wrap leaves high", 2'd0, 1'b1, 16'h0201);
        rd_chk("R3 no flag in split", 2'd2, 1'b0, 16'h0000);

        cur_req = "R9";
        rd_chk("R9 byte read high", 2'd0, 1'b0, 16'h0002);
        rd_chk("R9 byte read low", 2'd1, 1'b0, 16'h0001);
        bus_write(2'd1, 1'b1, 16'hAB77);
        rd_chk("R9 word flag ignored at addr 1", 2'd0, 1'b1, 16'h0277);

        cur_req = "R8";
        bus_write(2'd0, 1'b1, 16'h1234);
        rd_chk("R8 word write and read", 2'd0, 1'b1, 16'h1234);

        cur_req = "R4";
        @(negedge clk); casc_en = 1'b1;
        wait_cyc(2);
        bus_write(2'd0, 1'b1, 16'hFFFE);
        pulse(0); pulse(1); pulse(0); pulse(1); pulse(0);
        wait_cyc(4);
        rd_chk("R4 cascade count", 2'd0, 1'b1, 16'h0001);
        rd_chk("R5 overflow sets flag", 2'd2, 1'b0, 16'h0001);

        cur_req = "R7";
        check("R7 irq with enable", 32'(irq), 32'h1);
        @(negedge clk); irq_en = 1'b0; #1;
        check("R7 irq masked", 32'(irq), 32'h0);
        @(negedge clk); irq_en = 1'b1;

        cur_req = "R6";
        bus_write(2'd2, 1'b0, 16'hFFFE);
        rd_chk("R6 zero bit keeps flag", 2'd2, 1'b0, 16'h0001);
        bus_write(2'd2, 1'b0, 16'h0001);
        rd_chk("R6 one clears flag", 2'd2, 1'b0, 16'h0000);

        cur_req = "R10";
        @(negedge clk); casc_en = 1'b0;
        wait_cyc(2);
        bus_write(2'd0, 1'b1, 16'h0010);
        pulse_with_write(0, 2'd1, 1'b0, 16'h0040);
        wait_cyc(3);
        rd_chk("R10 split write beats increment", 2'd0, 1'b1, 16'h0040);
        @(negedge clk); casc_en = 1'b1;
        wait_cyc(2);
        bus_write(2'd0, 1'b1, 16'h12FF);
        pulse_with_write(0, 2'd1, 1'b0, 16'h0005);
        wait_cyc(3);
        rd_chk("R10 low write kills carry", 2'd0, 1'b1, 16'h1205);
        bus_write(2'd0, 1'b1, 16'h12FF);
        pulse_with_write(0, 2'd0, 1'b0, 16'h0055);
        wait_cyc(3);
        rd_chk("R10 high write beats carry", 2'd0, 1'b1, 16'h5500);
        bus_write(2'd0, 1'b1, 16'hFFFF);
        pulse_with_write(0, 2'd0, 1'b0, 16'h00AA);
        wait_cyc(3);
        rd_chk("R10 high write count", 2'd0, 1'b1, 16'hAA00);
        rd_chk("R10 no overflow after write", 2'd2, 1'b0, 16'h0000);

        cur_req = "R6";
        bus_write(2'd0, 1'b1, 16'hFFFF);
        pulse_with_write(0, 2'd2, 1'b0, 16'h0001);
        wait_cyc(3);
        rd_chk("R6 set wins over clear", 2'd2, 1'b0, 16'h0001);
        bus_write(2'd2, 1'b0, 16'h0001);

        cur_req = "R5";
        @(negedge clk); casc_en = 1'b0;
        wait_cyc(2);
        bus_write(2'd0, 1'b1, 16'hFFFF);
        pulse(1); pulse(0);
        wait_cyc(4);
        rd_chk("R5 split wraps count", 2'd0, 1'b1, 16'h0000);
        rd_chk("R5 no flag in split", 2'd2, 1'b0, 16'h0000);

        cur_req = "R11";
        @(negedge clk); casc_en = 1'b1;
        wait_cyc(2);
        bus_write(2'd0, 1'b1, 16'h00FF);
        @(negedge clk); casc_en = 1'b0; pin[0] = 1'b1;
        @(negedge clk); pin[0] = 1'b0;
        wait_cyc(3);
        rd_chk("R11 mode left before carry", 2'd0, 1'b1, 16'h0000);

        cur_req = "R12";
        @(negedge clk); sel = 1'b0; #1;
        check("R12 no select reads zero", 32'(rdata), 32'h0);
        rd_chk("R12 addr 3 reads zero", 2'd3, 1'b0, 16'h0000);
        @(negedge clk); sel = 1; wr = 1; word = 1; addr = 2'd3; wdata = 16'hFFFF; #1;
        check("R12 write cycle reads zero", 32'(rdata), 32'h0);

        cur_req = "R4 mixed";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            pin = 2'($urandom);
            if ($urandom % 64 == 0) casc_en = ~casc_en;
            if ($urandom % 50 == 0) irq_en = ~irq_en;
            case ($urandom % 8)
                0: begin sel = 1; wr = 1; word = 1'($urandom); addr = 2'($urandom); wdata = 16'($urandom); end
                1: begin sel = 0; wr = 1'($urandom); end
                2: begin sel = 1; wr = 1; word = 0; addr = 2'd2; wdata = 16'($urandom); end
                default: begin sel = 1; wr = 0; word = 1'($urandom); addr = 2'($urandom); end
            endcase
        end
        @(negedge clk); idle(); pin = 2'b00;
        wait_cyc(4);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule